// File: doc/BRIEF.md
# Debug Memory Access Command Checker

This block sits between a decoded stream of debug commands and the memory bus. Each command brings a command code, an access size and an address. For a memory access, the block produces a naturally aligned bus address in the same cycle, and the bus answers with read data on `rd_data` in that same cycle. One cycle later the block registers a response. The response holds the address that was used, the size that was used, the formatted read data and a flag for an illegal command.

Misaligned addresses never cause an error. The block clears the low address bits that the access size does not allow. The two block-transfer commands continue the previous access: dump continues a read, and fill continues a write. Each one reuses the stored size and moves the stored address forward by one access width. A block transfer that does not come directly after an allowed predecessor command gets an illegal-command response.

Command codes on `cmd_code`: 1 is a memory read, 2 is a memory write, 3 is a dump, 4 is a fill. The values 0, 5, 6 and 7 are non-memory commands. Size codes on `cmd_size` and `rsp_size`: 0 is byte, 1 is word (2 bytes), 2 is long (4 bytes). The value 3 is handled as long.

Top module: `dbgmem_access_chk`

## Requirements
- R1: A read or write with size long (code 2, or 3, which is handled as long) uses the address with bits [1:0] cleared. The same address appears on `bus_addr` in the command cycle and on `rsp_addr` one cycle later, and `rsp_size` reads 2.
- R2: A read or write with size word uses the address with bit 0 cleared. A byte access uses the address unchanged. `rsp_size` reports 1 for word and 0 for byte.
- R3: A read or write command never gets an error response, whatever its address: `rsp_illegal` stays 0.
- R4: The response data of a legal read or dump is the read data packed by size. Byte gives `rd_data[7:0]` in bits [7:0]. Word gives `rd_data[15:0]` in bits [15:0]. Long gives all 32 bits. Every bit above the access width is 0. A legal write or fill returns data 0.
- R5: A dump is legal only when the command just before it (cycles with `cmd_valid` low do not count) was a read or a legal dump. Otherwise `rsp_illegal` is 1.
- R6: A fill is legal only when the command just before it was a write or a legal fill. Otherwise `rsp_illegal` is 1.
- R7: A legal dump or fill ignores `cmd_size` and `cmd_addr`. It reuses the stored size and uses the stored address plus 1, 2 or 4 bytes, wrapping modulo 2^32. That new address becomes the stored address.
- R8: A non-memory command clears the stored predecessor, so the next dump or fill is illegal. Its response has `rsp_illegal` 0, data 0, address 0 and size 0, and `bus_addr` is 0 during it. An illegal dump or fill also clears the predecessor.
- R9: An illegal response carries `rsp_data` 0, `rsp_addr` 0 and `rsp_size` 0, and `bus_addr` is 0 in that command cycle.
- R10: `rsp_valid` is 1 exactly one cycle after each cycle with `cmd_valid` high and 0 otherwise. After reset, `rsp_valid` and `rsp_illegal` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_code | input | 3 | Command code (1 read, 2 write, 3 dump, 4 fill, others non-memory) |
| cmd_size | input | 2 | Access size (0 byte, 1 word, 2/3 long) |
| cmd_addr | input | ADDR_W | Requested byte address |
| rd_data | input | DATA_W | Bus read data for `bus_addr`, valid in the same cycle |
| bus_addr | output | ADDR_W | Aligned bus address of the current legal access, 0 otherwise |
| rsp_valid | output | 1 | A response is present |
| rsp_illegal | output | 1 | Illegal-command response |
| rsp_size | output | 2 | Access size actually used |
| rsp_addr | output | ADDR_W | Aligned address actually used |
| rsp_data | output | DATA_W | Packed read data, 0 for writes and other commands |

## Verification
The stored predecessor kind, address and size are only visible through later block transfers. A wrong predecessor kind therefore shows up as a wrong `rsp_illegal` one cycle after the next dump or fill. A wrong stored address or size shows up on `bus_addr` in the cycle of that dump or fill, and on `rsp_addr` and `rsp_size` one cycle later. The stimulus therefore sends chains of block transfers after random reads and writes, placing non-memory commands and idle gaps in between. Each step is compared against a bench model of the stored state.

// File: rtl/dbgmem_pkg.sv
package dbgmem_pkg;

  typedef enum logic [2:0] {
    DC_OTHER = 3'd0,
    DC_READ  = 3'd1,
    DC_WRITE = 3'd2,
    DC_DUMP  = 3'd3,
    DC_FILL  = 3'd4
  } dcmd_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } dsize_e;

  typedef enum logic [1:0] {
    PRED_NONE = 2'd0,
    PRED_RD   = 2'd1,
    PRED_WR   = 2'd2
  } pred_e;

  // reserved size code is handled as a long access
  function automatic logic [1:0] norm_size(input logic [1:0] s);
    return (s == SZ_RSVD) ? SZ_LONG : s;
  endfunction

  function automatic logic [2:0] size_bytes(input logic [1:0] s);
    case (s)
      SZ_BYTE: return 3'd1;
      SZ_WORD: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // low address bits that an access of this size must not carry
  function automatic logic [1:0] drop_mask(input logic [1:0] s);
    case (s)
      SZ_BYTE: return 2'b00;
      SZ_WORD: return 2'b01;
      default: return 2'b11;
    endcase
  endfunction

  function automatic logic is_blk(input logic [2:0] code);
    return (code == DC_DUMP) || (code == DC_FILL);
  endfunction

  function automatic logic is_mem(input logic [2:0] code);
    return (code == DC_READ) || (code == DC_WRITE);
  endfunction

  function automatic logic blk_allowed(input logic [2:0] code, input logic [1:0] pred);
    return ((code == DC_DUMP) && (pred == PRED_RD)) ||
           ((code == DC_FILL) && (pred == PRED_WR));
  endfunction

endpackage

// File: rtl/dbgmem_align.sv
module dbgmem_align #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] raw_addr,
  input  logic [1:0]        size,
  output logic [ADDR_W-1:0] aligned_addr
);
  import dbgmem_pkg::*;

  logic [ADDR_W-1:0] clr_mask;

  always_comb begin
    clr_mask      = '0;
    clr_mask[1:0] = drop_mask(size);
    aligned_addr  = raw_addr & ~clr_mask;
  end
endmodule

// File: rtl/dbgmem_rsp_fmt.sv
module dbgmem_rsp_fmt #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] bus_data,
  input  logic [1:0]        size,
  output logic [DATA_W-1:0] packed_data
);
  import dbgmem_pkg::*;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;

  always_comb begin
    packed_data = '0;
    case (size)
      SZ_BYTE: packed_data[BYTE_W-1:0] = bus_data[BYTE_W-1:0];
      SZ_WORD: packed_data[WORD_W-1:0] = bus_data[WORD_W-1:0];
      default: packed_data             = bus_data;
    endcase
  end
endmodule

// File: rtl/dbgmem_pred_track.sv
module dbgmem_pred_track #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_code,
  input  logic [ADDR_W-1:0] new_addr,
  input  logic [1:0]        new_size,
  output logic [1:0]        pred,
  output logic [ADDR_W-1:0] base_addr,
  output logic [1:0]        base_size,
  output logic              blk_cmd,
  output logic              blk_legal,
  output logic [ADDR_W-1:0] next_addr
);
  import dbgmem_pkg::*;

  assign blk_cmd   = is_blk(cmd_code);
  assign blk_legal = blk_allowed(cmd_code, pred);
  assign next_addr = base_addr + ADDR_W'(size_bytes(base_size));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred      <= PRED_NONE;
      base_addr <= '0;
      base_size <= SZ_BYTE;
    end else if (cmd_valid) begin
      case (cmd_code)
        DC_READ: begin
          pred      <= PRED_RD;
          base_addr <= new_addr;
          base_size <= new_size;
        end
        DC_WRITE: begin
          pred      <= PRED_WR;
          base_addr <= new_addr;
          base_size <= new_size;
        end
        DC_DUMP, DC_FILL: begin
          if (blk_legal) base_addr <= next_addr;
          else           pred      <= PRED_NONE;
        end
        default: pred <= PRED_NONE;
      endcase
    end
  end
endmodule

// File: rtl/dbgmem_access_chk.sv
module dbgmem_access_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_code,
  input  logic [1:0]        cmd_size,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              rsp_valid,
  output logic              rsp_illegal,
  output logic [1:0]        rsp_size,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [DATA_W-1:0] rsp_data
);
  import dbgmem_pkg::*;

  // named internal events
  logic [1:0]        req_size;
  logic [ADDR_W-1:0] req_aligned;
  logic [1:0]        pred;
  logic [ADDR_W-1:0] base_addr;
  logic [1:0]        base_size;
  logic              blk_cmd;
  logic              blk_legal;
  logic [ADDR_W-1:0] next_addr;
  logic              mem_cmd;
  logic              acc_legal;
  logic              acc_reads;
  logic              acc_illegal;
  logic [1:0]        acc_size;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] fmt_data;

  assign req_size = norm_size(cmd_size);

  dbgmem_align #(.ADDR_W(ADDR_W)) u_align (
    .raw_addr     (cmd_addr),
    .size         (req_size),
    .aligned_addr (req_aligned)
  );

  dbgmem_pred_track #(.ADDR_W(ADDR_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .new_addr  (req_aligned),
    .new_size  (req_size),
    .pred      (pred),
    .base_addr (base_addr),
    .base_size (base_size),
    .blk_cmd   (blk_cmd),
    .blk_legal (blk_legal),
    .next_addr (next_addr)
  );

  assign mem_cmd     = is_mem(cmd_code);
  assign acc_legal   = cmd_valid && (mem_cmd || (blk_cmd && blk_legal));
  assign acc_illegal = cmd_valid && blk_cmd && !blk_legal;
  assign acc_reads   = (cmd_code == DC_READ) || (cmd_code == DC_DUMP);
  assign acc_size    = blk_cmd ? base_size : req_size;
  assign acc_addr    = blk_cmd ? next_addr : req_aligned;
  assign bus_addr    = acc_legal ? acc_addr : '0;

  dbgmem_rsp_fmt #(.DATA_W(DATA_W)) u_fmt (
    .bus_data    (rd_data),
    .size        (acc_size),
    .packed_data (fmt_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_illegal <= 1'b0;
      rsp_size    <= SZ_BYTE;
      rsp_addr    <= '0;
      rsp_data    <= '0;
    end else begin
      rsp_valid   <= cmd_valid;
      rsp_illegal <= acc_illegal;
      rsp_size    <= acc_legal ? acc_size : SZ_BYTE;
      rsp_addr    <= acc_legal ? acc_addr : '0;
      rsp_data    <= (acc_legal && acc_reads) ? fmt_data : '0;
    end
  end
endmodule

// File: rtl/dbgmem_access_chk_sva.sv
module dbgmem_access_chk_sva #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [2:0]        cmd_code,
  input logic              rsp_valid,
  input logic              rsp_illegal,
  input logic [1:0]        rsp_size,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic [DATA_W-1:0] rsp_data,
  input logic [1:0]        pred,
  input logic [ADDR_W-1:0] base_addr,
  input logic [1:0]        base_size,
  input logic              blk_cmd,
  input logic              blk_legal
);
  import dbgmem_pkg::*;

  assert_long_align_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_size == SZ_LONG |-> rsp_addr[1:0] == 2'b00);

  assert_word_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_size == SZ_WORD |-> rsp_addr[0] == 1'b0);

  assert_no_addr_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_code == DC_READ || cmd_code == DC_WRITE) |=> !rsp_illegal);

  assert_byte_pack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_size == SZ_BYTE |-> rsp_data[DATA_W-1:8] == '0);

  assert_dump_pred_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_code == DC_DUMP && pred != PRED_RD |=> rsp_illegal);

  assert_fill_pred_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_code == DC_FILL && pred != PRED_WR |=> rsp_illegal);

  assert_blk_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && blk_cmd && blk_legal |=>
      rsp_addr == $past(base_addr) + ADDR_W'(size_bytes($past(base_size))) &&
      rsp_size == $past(base_size));

  assert_clear_pred_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !is_mem(cmd_code) && !(blk_cmd && blk_legal) |=> pred == PRED_NONE);

  assert_illegal_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_illegal |-> rsp_data == '0 && rsp_addr == '0 && rsp_size == SZ_BYTE);

  assert_rsp_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rsp_valid);

  assert_rsp_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !rsp_valid && !rsp_illegal);

endmodule

bind dbgmem_access_chk dbgmem_access_chk_sva #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_code    (cmd_code),
  .rsp_valid   (rsp_valid),
  .rsp_illegal (rsp_illegal),
  .rsp_size    (rsp_size),
  .rsp_addr    (rsp_addr),
  .rsp_data    (rsp_data),
  .pred        (pred),
  .base_addr   (base_addr),
  .base_size   (base_size),
  .blk_cmd     (blk_cmd),
  .blk_legal   (blk_legal)
);

// File: tb/sim_dbgmem_access_chk.sv
module sim_dbgmem_access_chk;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_code = 3'd0;
  logic [1:0]  cmd_size = 2'd0;
  logic [31:0] cmd_addr = 32'd0;
  logic [31:0] rd_data = 32'd0;
  logic [31:0] bus_addr;
  logic        rsp_valid;
  logic        rsp_illegal;
  logic [1:0]  rsp_size;
  logic [31:0] rsp_addr;
  logic [31:0] rsp_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model of the predecessor: 0 none, 1 read-like, 2 write-like
  int          m_kind = 0;
  logic [31:0] m_addr = 32'd0;
  logic [1:0]  m_size = 2'd0;

  always #10 clk = ~clk;

  dbgmem_access_chk u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_size(cmd_size), .cmd_addr(cmd_addr), .rd_data(rd_data),
    .bus_addr(bus_addr), .rsp_valid(rsp_valid), .rsp_illegal(rsp_illegal),
    .rsp_size(rsp_size), .rsp_addr(rsp_addr), .rsp_data(rsp_data)
  );

  function automatic int nbytes(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] b_align(input logic [31:0] a, input logic [1:0] s);
    return a - (a % nbytes(s));
  endfunction

  function automatic logic [31:0] b_pack(input logic [31:0] d, input logic [1:0] s);
    if (s == 2'd0) return d % 256;
    if (s == 2'd1) return d % 65536;
    return d;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic run_cmd(input logic [2:0] code, input logic [1:0] size,
                         input logic [31:0] addr, input logic [31:0] data);
    bit          is_rd, is_wr, is_blk, legal, illegal, reads;
    logic [1:0]  e_size;
    logic [31:0] e_addr, e_data;
    string       t_addr, t_data, t_ill;
    is_rd  = (code == 3'd1);
    is_wr  = (code == 3'd2);
    is_blk = (code == 3'd3) || (code == 3'd4);
    legal  = is_rd || is_wr || (code == 3'd3 && m_kind == 1) || (code == 3'd4 && m_kind == 2);
    illegal = is_blk && !legal;
    reads  = (code == 3'd1) || (code == 3'd3);
    e_size = 2'd0; e_addr = 32'd0; e_data = 32'd0;
    if (legal) begin
      if (is_blk) begin
        e_size = m_size;
        e_addr = m_addr + nbytes(m_size);
      end else begin
        e_size = (size == 2'd3) ? 2'd2 : size;
        e_addr = b_align(addr, e_size);
      end
      if (reads) e_data = b_pack(data, e_size);
    end
    t_addr = is_blk ? (legal ? "R7" : "R9") : (is_rd || is_wr) ? ((e_size == 2'd2) ? "R1" : "R2") : "R8";
    t_data = illegal ? "R9" : (is_rd || is_wr || is_blk) ? "R4" : "R8";
    t_ill  = is_rd || is_wr ? "R3" : (code == 3'd3) ? "R5" : (code == 3'd4) ? "R6" : "R8";

    cmd_valid = 1'b1; cmd_code = code; cmd_size = size; cmd_addr = addr; rd_data = data;
    #2;
    chk(t_addr, "bus_addr", bus_addr, e_addr);
    @(negedge clk);
    chk("R10", "rsp_valid", {31'd0, rsp_valid}, 32'd1);
    chk(t_ill, "rsp_illegal", {31'd0, rsp_illegal}, {31'd0, illegal});
    chk(t_addr, "rsp_addr", rsp_addr, e_addr);
    chk(t_addr, "rsp_size", {30'd0, rsp_size}, {30'd0, e_size});
    chk(t_data, "rsp_data", rsp_data, e_data);
    // model update
    if (is_rd || is_wr) begin
      m_kind = is_rd ? 1 : 2; m_addr = e_addr; m_size = e_size;
    end else if (is_blk && legal) begin
      m_addr = e_addr;
    end else begin
      m_kind = 0;
    end
  endtask

  task automatic idle(input int n);
    cmd_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R10", "rsp_valid idle", {31'd0, rsp_valid}, 32'd0);
    end
  endtask

  function automatic logic [2:0] pick_code(input int r);
    if (r < 30) return 3'd1;
    if (r < 50) return 3'd2;
    if (r < 72) return 3'd3;
    if (r < 92) return 3'd4;
    return (r < 96) ? 3'd0 : 3'd5 + 3'(r % 3);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_1234);
    repeat (3) @(negedge clk);
    chk("R10", "reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R10", "reset rsp_illegal", {31'd0, rsp_illegal}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    run_cmd(3'd3, 2'd0, 32'h10, 32'h55);            // R5 dump with no predecessor
    run_cmd(3'd1, 2'd2, 32'h1003, 32'hCAFEF00D);    // R1 long read, low bits dropped
    run_cmd(3'd4, 2'd0, 32'h0, 32'h0);              // R6 fill after read is illegal
    run_cmd(3'd1, 2'd3, 32'hFFFF_FFFE, 32'h1234_5678); // R1 reserved size as long
    run_cmd(3'd3, 2'd0, 32'hDEAD_BEEF, 32'h8765_4321); // R7 wrap to 0, size/addr ignored
    idle(2);
    run_cmd(3'd3, 2'd1, 32'h0BAD, 32'hAAAA_5555);   // R5 idle gap keeps legality
    run_cmd(3'd1, 2'd0, 32'h2001, 32'hFFFF_FFA5);   // R4 byte packing
    run_cmd(3'd3, 2'd2, 32'h0, 32'hFFFF_FF3C);      // R7 byte step
    run_cmd(3'd2, 2'd1, 32'h3007, 32'h0);           // R2 word write
    run_cmd(3'd4, 2'd0, 32'h0, 32'h0);              // R7 word step fill
    run_cmd(3'd3, 2'd0, 32'h0, 32'h0);              // R5 dump after fill illegal
    run_cmd(3'd2, 2'd0, 32'h4001, 32'h0);
    run_cmd(3'd6, 2'd0, 32'h0, 32'h0);              // R8 non-memory clears
    run_cmd(3'd4, 2'd0, 32'h0, 32'h0);              // R8 fill now illegal
    run_cmd(3'd1, 2'd1, 32'h5003, 32'hBEEF_1357);   // R2 word read packing
    run_cmd(3'd3, 2'd0, 32'h0, 32'h2468_ACE0);

    // constrained random
    for (int i = 0; i < 600; i++) begin
      logic [2:0] c;
      c = pick_code(int'($urandom % 100));
      run_cmd(c, 2'($urandom % 4), $urandom, $urandom);
      if ($urandom % 16 == 0) idle(1);
    end
    idle(2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule